// File: doc/BRIEF.md
# Energy-Detect Wake Event Controller

This block sits between the PHY of a network interface and the host bus and turns line activity into a power-management wake request. The PHY raises an interrupt when it sees energy on the cable. The block brings that interrupt into its clock domain, records it in a sticky wake-status bit, and raises a PME status bit when energy wake is enabled. It drives an active-low PME output to the host whenever PME is both enabled and pending.

The block also owns a two-bit power-state field. When the host selects D3, the block picks one of two PHY low-power controls. If PME is enabled, the PHY goes into energy-detect power-down, where it cannot move data but can still report activity. If PME is not enabled, the PHY is held in reset and in general power-down. Any other state value returns the block to D0 and releases the PHY.

The host reaches the register set through a synchronous write port and a registered read port. Status bits are cleared by writing one.

Top module: `edwake_ctrl`

## Requirements
- R1: After synchronous reset, every enable and status bit reads 0, the power state is D0, `pme_n_o` is high and all three PHY controls are low. A read of any address other than 0 or 1 returns 0.
- R2: `phy_irq_i` passes through two synchronizing flip-flops. A rising edge of the synchronized level sets the wake-status bit (address 1, bit 0) only when the interrupt-source enable (address 0, bit 0) is 1. Otherwise the edge is ignored.
- R3: Writing 1 to wake-status bit (address 1, bit 0) clears it only while the synchronized PHY interrupt is low. While the interrupt is high, the write has no effect.
- R4: When wake status and the energy wake enable (address 0, bit 1) both become 1, PME status (address 1, bit 1) is set. This includes setting the enable while wake status is already 1.
- R5: PME status is sticky. Only a write of 1 to address 1, bit 1 clears it. It is not set again until wake status and energy wake enable newly become both 1.
- R6: `pme_n_o` is a registered output. It is low exactly when PME enable (address 0, bit 2) and PME status are both 1, and it returns high once either is cleared.
- R7: The power-state field is address 0, bits 5:4. A written value of 2'b11 selects D3, and any other written value stores 2'b00 (D0). Address 0 bit 3 and bits above 5 always read 0.
- R8: In D3 with PME enable set, `phy_edpd_o` is high and `phy_pd_o` and `phy_rst_o` are low.
- R9: In D3 with PME enable clear, `phy_pd_o` and `phy_rst_o` are high and `phy_edpd_o` is low.
- R10: In D0, all PHY controls are low. Returning from D3 to D0 leaves wake status and PME status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_irq_i | input | 1 | Asynchronous energy-detect interrupt from the PHY |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address (0 control, 1 status) |
| wdata_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data for the address given one cycle earlier |
| pme_n_o | output | 1 | Active-low power-management event to the host |
| phy_edpd_o | output | 1 | PHY energy-detect power-down request |
| phy_pd_o | output | 1 | PHY general power-down request |
| phy_rst_o | output | 1 | PHY reset |

## Verification
Assertions check several rules on every cycle:
- a clear of wake status is blocked while the interrupt is high;
- PME status stays set;
- the power-state field only ever holds D0 or D3;
- the PME pin and the PHY controls follow their enables one cycle later.

Other behaviour can only be shown by the bench's scenarios:
- an ignored edge when the source enable is off;
- the immediate wake when the enable is set late;
- a PME that can be cleared and later raised again;
- status kept across a return to D0.

Randomized control writes compare readback, the PME pin and the PHY controls against values computed in the bench.

// File: rtl/edwake_pkg.sv
package edwake_pkg;
  localparam int unsigned CTRL_ADDR  = 0;
  localparam int unsigned STAT_ADDR  = 1;
  localparam int unsigned C_SRC_BIT  = 0;
  localparam int unsigned C_EDW_BIT  = 1;
  localparam int unsigned C_PME_BIT  = 2;
  localparam int unsigned C_PS_LSB   = 4;
  localparam int unsigned S_WAKE_BIT = 0;
  localparam int unsigned S_PME_BIT  = 1;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D3 = 2'b11
  } pstate_e;
endpackage

// File: rtl/edwake_sync.sv
module edwake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("edwake_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/edwake_regs.sv
module edwake_regs
  import edwake_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_level_i,
  input  logic              irq_rise_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pme_en_o,
  output logic              pme_sts_o,
  output logic              d3_o
);
  logic    src_en_q, edw_en_q, pme_en_q;
  logic    wake_q, pme_sts_q, evt_q;
  pstate_e pstate_q;
  logic    ctrl_wr, stat_wr, evt;
  logic [DATA_W-1:0] rd_next;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(CTRL_ADDR));
  assign stat_wr = wr_en_i && (addr_i == ADDR_W'(STAT_ADDR));
  assign evt     = wake_q && edw_en_q;

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_W'(CTRL_ADDR)) begin
      rd_next[C_SRC_BIT]       = src_en_q;
      rd_next[C_EDW_BIT]       = edw_en_q;
      rd_next[C_PME_BIT]       = pme_en_q;
      rd_next[C_PS_LSB +: 2]   = pstate_q;
    end else if (addr_i == ADDR_W'(STAT_ADDR)) begin
      rd_next[S_WAKE_BIT] = wake_q;
      rd_next[S_PME_BIT]  = pme_sts_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en_q  <= 1'b0;
      edw_en_q  <= 1'b0;
      pme_en_q  <= 1'b0;
      pstate_q  <= PS_D0;
      wake_q    <= 1'b0;
      pme_sts_q <= 1'b0;
      evt_q     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (ctrl_wr) begin
        src_en_q <= wdata_i[C_SRC_BIT];
        edw_en_q <= wdata_i[C_EDW_BIT];
        pme_en_q <= wdata_i[C_PME_BIT];
        pstate_q <= (wdata_i[C_PS_LSB +: 2] == 2'b11) ? PS_D3 : PS_D0;
      end
      if (irq_rise_i && src_en_q)
        wake_q <= 1'b1;
      else if (stat_wr && wdata_i[S_WAKE_BIT] && !irq_level_i)
        wake_q <= 1'b0;
      evt_q <= evt;
      if (evt && !evt_q)
        pme_sts_q <= 1'b1;
      else if (stat_wr && wdata_i[S_PME_BIT])
        pme_sts_q <= 1'b0;
      rd_data_o <= rd_next;
    end
  end

  assign pme_en_o  = pme_en_q;
  assign pme_sts_o = pme_sts_q;
  assign d3_o      = (pstate_q == PS_D3);

  p_wake_set_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_rise_i && src_en_q) |=> wake_q);
  p_clr_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata_i[S_WAKE_BIT] && irq_level_i && wake_q) |=> wake_q);
  p_pme_set_r4: assert property (@(posedge clk) disable iff (rst)
    (evt && !evt_q) |=> pme_sts_q);
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (pme_sts_q && !(stat_wr && wdata_i[S_PME_BIT])) |=> pme_sts_q);
  p_pstate_r7: assert property (@(posedge clk) disable iff (rst)
    (pstate_q == PS_D0) || (pstate_q == PS_D3));
endmodule

// File: rtl/edwake_pwr.sv
module edwake_pwr (
  input  logic clk,
  input  logic rst,
  input  logic pme_en_i,
  input  logic pme_sts_i,
  input  logic d3_i,
  output logic pme_n_o,
  output logic phy_edpd_o,
  output logic phy_pd_o,
  output logic phy_rst_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pme_n_o    <= 1'b1;
      phy_edpd_o <= 1'b0;
      phy_pd_o   <= 1'b0;
      phy_rst_o  <= 1'b0;
    end else begin
      pme_n_o    <= ~(pme_en_i & pme_sts_i);
      phy_edpd_o <= d3_i & pme_en_i;
      phy_pd_o   <= d3_i & ~pme_en_i;
      phy_rst_o  <= d3_i & ~pme_en_i;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pme_n_o && !phy_edpd_o && !phy_pd_o && !phy_rst_o));
  p_pme_low_r6: assert property (@(posedge clk) disable iff (rst)
    (pme_en_i && pme_sts_i) |=> !pme_n_o);
  p_pme_high_r6: assert property (@(posedge clk) disable iff (rst)
    !(pme_en_i && pme_sts_i) |=> pme_n_o);
  p_edpd_r8: assert property (@(posedge clk) disable iff (rst)
    (d3_i && pme_en_i) |=> (phy_edpd_o && !phy_pd_o && !phy_rst_o));
  p_fullpd_r9: assert property (@(posedge clk) disable iff (rst)
    (d3_i && !pme_en_i) |=> (phy_pd_o && phy_rst_o && !phy_edpd_o));
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    !d3_i |=> (!phy_edpd_o && !phy_pd_o && !phy_rst_o));
endmodule

// File: rtl/edwake_ctrl.sv
module edwake_ctrl #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phy_irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pme_n_o,
  output logic              phy_edpd_o,
  output logic              phy_pd_o,
  output logic              phy_rst_o
);
  logic irq_level, irq_rise, pme_en, pme_sts, d3;

  edwake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(phy_irq_i),
    .level_o(irq_level), .rise_o(irq_rise)
  );

  edwake_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .irq_level_i(irq_level), .irq_rise_i(irq_rise),
    .rd_data_o(rd_data_o), .pme_en_o(pme_en), .pme_sts_o(pme_sts),
    .d3_o(d3)
  );

  edwake_pwr u_pwr (
    .clk(clk), .rst(rst), .pme_en_i(pme_en), .pme_sts_i(pme_sts),
    .d3_i(d3), .pme_n_o(pme_n_o), .phy_edpd_o(phy_edpd_o),
    .phy_pd_o(phy_pd_o), .phy_rst_o(phy_rst_o)
  );
endmodule

// File: tb/edwake_ctrl_bench.sv
module edwake_ctrl_bench;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phy_irq = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic pme_n, edpd, pd, prst;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edwake_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_edwake_ctrl (
    .clk(clk), .rst(rst), .phy_irq_i(phy_irq), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data), .pme_n_o(pme_n),
    .phy_edpd_o(edpd), .phy_pd_o(pd), .phy_rst_o(prst)
  );

  function automatic logic [7:0] exp_ctrl(input logic [7:0] b);
    return (b & 8'h07) | ((b[5:4] == 2'b11) ? 8'h30 : 8'h00);
  endfunction

  function automatic logic [2:0] exp_phy(input logic [7:0] b);
    logic d3 = (b[5:4] == 2'b11);
    return {d3 & b[2], d3 & ~b[2], d3 & ~b[2]};  // {edpd, pd, rst}
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pme_n", pme_n, 1);
    check("R1 phy", {edpd, pd, prst}, 0);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 stat", v, 0);
    rd(2, v); check("R1 unmapped", v, 0);

    // R2 edge ignored with source enable off
    phy_irq = 1'b1; settle(); phy_irq = 1'b0; settle();
    rd(1, v); check("R2 ignored", v, 0);

    // R2 edge sets wake status with source enable on
    wr(0, 8'h01);
    phy_irq = 1'b1; settle();
    rd(1, v); check("R2 wake set", v, 8'h01);

    // R3 clear blocked while interrupt high
    wr(1, 8'h01); settle();
    rd(1, v); check("R3 clear blocked", v, 8'h01);
    phy_irq = 1'b0; settle();
    wr(1, 8'h01);
    rd(1, v); check("R3 clear ok", v, 0);

    // R4 enable set late with status already set
    phy_irq = 1'b1; settle(); phy_irq = 1'b0; settle();
    wr(0, 8'h03); settle();
    rd(1, v); check("R4 late enable", v, 8'h03);
    check("R6 pme_n no enable", pme_n, 1);
    wr(0, 8'h07); settle();
    check("R6 pme_n asserted", pme_n, 0);

    // R5 W1C of PME status, no re-set without new event
    wr(1, 8'h02); settle();
    rd(1, v); check("R5 pme cleared", v, 8'h01);
    check("R6 pme_n released by status", pme_n, 1);

    // R4 fresh wake event raises PME again
    wr(1, 8'h01); settle();
    phy_irq = 1'b1; settle(); phy_irq = 1'b0; settle();
    check("R4 new event pme_n", pme_n, 0);
    wr(0, 8'h03); settle();
    check("R6 pme_n released by enable", pme_n, 1);
    rd(1, v); check("R5 sticky", v, 8'h03);

    // R8 / R9 D3 variants
    wr(0, 8'h37); settle();
    check("R8 edpd", {edpd, pd, prst}, 3'b100);
    rd(0, v); check("R7 ctrl d3", v, 8'h37);
    wr(0, 8'h33); settle();
    check("R9 full pd", {edpd, pd, prst}, 3'b011);

    // R7 / R10 leave D3 with non-11 value
    wr(0, 8'hE7); settle();
    rd(0, v); check("R7 normalize", v, 8'h07);
    check("R10 phy released", {edpd, pd, prst}, 0);
    rd(1, v); check("R10 status kept", v, 8'h03);

    // random control writes; status stays 0x03
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      wr(0, b); settle();
      rd(0, v); check("R7 random ctrl", v, exp_ctrl(b));
      check("R8 R9 random phy", {edpd, pd, prst}, exp_phy(b));
      check("R6 random pme_n", pme_n, b[2] ? 0 : 1);
      rd(1, v); check("R10 random stat", v, 8'h03);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule